// File: doc/BRIEF.md
# Control Bus Master with Response Timeout

This block is the only initiator on a narrow register-access bus. A processor hands it one read or write at a time through a valid/ready request port. The block then drives the command onto the bus. Address and write data share a single multiplexed signal, so a write takes an address cycle followed by a data cycle, and a read takes a single address cycle. After the command the block waits for the addressed slave to pulse a valid strobe. That strobe acknowledges the transfer and, for a read, carries the read data. No second command is issued while a response is outstanding, so a slave's internal command queue can never be overrun.

A response timer counts the cycles spent waiting. If the strobe does not arrive in time, the attempt has failed. A plain control input then decides what happens next. In discard mode the command finishes at once with an error. In retry mode the whole command is issued again, with the same address and data, up to a parameterised number of extra attempts. The error is reported only after the last attempt fails. The processor side sees a busy flag, a one-cycle done pulse, an error flag and the read data.

The request port follows valid/ready rules. A command transfers on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while no command is in flight. A requester may hold `req_valid` and its payload for as long as it likes. Nothing is taken until `req_ready` rises again.

Top module: `ctl_bus_master`

## Requirements
- R1: `req_ready` is 1 exactly when no command is in flight. A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. `busy` is 1 from the next cycle until the cycle that shows `done`. Requests presented while busy are not taken.
- R2: A write puts one address cycle on the bus (`bus_cmd`=1, `bus_wr`=1, `bus_ad` = address in the low ADDR_W bits with zero upper bits). The address cycle is immediately followed by one data cycle (`bus_dat`=1, `bus_wr`=1, `bus_ad` = write data).
- R3: A read puts one address cycle on the bus (`bus_cmd`=1, `bus_wr`=0) and has no data cycle. The block then waits for a response.
- R4: Outside address and data cycles, `bus_ad` is all zeros and `bus_wr` is 0.
- R5: While a response is awaited, no new command or data cycle is driven. `sl_vld` is acted on only in waiting cycles. A strobe at any other time changes neither `done`, `err` nor `rdata`.
- R6: A strobe in any of the first TIMEOUT waiting cycles completes the command. `done` is then 1 for exactly one cycle, in the cycle after the strobe, with `err`=0. For a read, `rdata` equals the `sl_rdata` that came with the strobe.
- R7: TIMEOUT waiting cycles without a strobe fail the attempt. If a strobe arrives in the same cycle the limit is reached, the strobe wins. With `retry_en`=0 the command ends after one attempt, with `done` and `err`=1.
- R8: With `retry_en`=1, a failed attempt is followed at once by a fresh address cycle carrying the same command, and the wait timer restarts. At most MAX_RETRY retries follow the first attempt. If the last one also fails, the command ends with `done` and `err`=1.
- R9: `err` holds the outcome of the most recently completed command until the next completion. `rdata` changes only on a successful read. Writes and failed reads leave it unchanged.
- R10: Counting from the edge that takes the request, `done` is visible in cycle N+1. N is the total length of all attempts. A failed attempt lasts P+TIMEOUT cycles, where P is 2 for a write and 1 for a read. A successful attempt whose strobe comes in waiting cycle d (counted from 0) lasts P+d+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| retry_en | input | 1 | 1: retry timed-out commands; 0: discard them with an error |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (block idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_wdata | input | DATA_W | Write data |
| busy | output | 1 | Command in flight |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last completed command failed |
| rdata | output | DATA_W | Data of the last successful read |
| bus_ad | output | DATA_W | Shared address / write-data signal |
| bus_cmd | output | 1 | Address cycle marker |
| bus_wr | output | 1 | Direction of the current bus cycle |
| bus_dat | output | 1 | Write-data cycle marker |
| sl_vld | input | 1 | Slave response strobe |
| sl_rdata | input | DATA_W | Slave read data, valid with `sl_vld` |

## Verification
The main function is exercised with reads and writes whose responses arrive at random delays, including the last legal waiting cycle and the first late one. These tell on-time completions apart from timeouts by the exact done latency. Slaves that stay silent for zero, some, exactly MAX_RETRY+1 and more attempts, run under both retry modes, separate successful retries from exhausted ones. These cases also show whether the attempt count and the error flag agree. Holding a changed request while busy, and pulsing the strobe while idle, show that neither is taken.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ADDR  = 2'd1,
    ST_WDATA = 2'd2,
    ST_WAIT  = 2'd3
  } cbm_state_e;

  // outcome of a waiting cycle
  typedef enum logic [1:0] {
    WR_PEND  = 2'd0,
    WR_OK    = 2'd1,
    WR_RETRY = 2'd2,
    WR_FAIL  = 2'd3
  } cbm_wait_res_e;
endpackage

// File: rtl/cbm_resp_timer.sv
module cbm_resp_timer #(
  parameter int TIMEOUT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int TW = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT);
  localparam logic [TW-1:0] LAST = TW'(TIMEOUT - 1);

  logic [TW-1:0] cnt_q;

  assign expired = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!run || expired)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cbm_retry_ctl.sv
module cbm_retry_ctl #(
  parameter int MAX_RETRY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic exhausted
);
  localparam int RW = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);

  generate
    if (MAX_RETRY == 0) begin : g_none
      assign exhausted = 1'b1;
    end else begin : g_cnt
      logic [RW-1:0] cnt_q;
      assign exhausted = (cnt_q == RW'(MAX_RETRY));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          cnt_q <= '0;
        else if (clear)
          cnt_q <= '0;
        else if (bump && !exhausted)
          cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/cbm_seq.sv
module cbm_seq
  import cbm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retry_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] bus_ad,
  output logic              bus_cmd,
  output logic              bus_wr,
  output logic              bus_dat,
  input  logic              sl_vld,
  input  logic [DATA_W-1:0] sl_rdata,
  output logic              tmr_run,
  input  logic              tmr_expired,
  output logic              rty_clear,
  output logic              rty_bump,
  input  logic              rty_exhausted
);
  cbm_state_e    st_q, st_d;
  cbm_wait_res_e wres;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              done_q, err_q;
  logic [DATA_W-1:0] rdata_q;
  logic              take;

  assign take      = (st_q == ST_IDLE) && req_valid;
  assign req_ready = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);
  assign tmr_run   = (st_q == ST_WAIT);
  assign rty_clear = take;

  // resolve a waiting cycle: strobe beats the timer
  always_comb begin
    wres = WR_PEND;
    if (st_q == ST_WAIT) begin
      if (sl_vld)
        wres = WR_OK;
      else if (tmr_expired)
        wres = (retry_en && !rty_exhausted) ? WR_RETRY : WR_FAIL;
    end
  end

  assign rty_bump = (wres == WR_RETRY);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_valid) st_d = ST_ADDR;
      ST_ADDR:  st_d = wr_q ? ST_WDATA : ST_WAIT;
      ST_WDATA: st_d = ST_WAIT;
      ST_WAIT: begin
        unique case (wres)
          WR_OK, WR_FAIL: st_d = ST_IDLE;
          WR_RETRY:       st_d = ST_ADDR;
          default:        st_d = ST_WAIT;
        endcase
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (take) begin
        wr_q    <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= (wres == WR_OK) || (wres == WR_FAIL);
      if (wres == WR_OK) begin
        err_q <= 1'b0;
        if (!wr_q) rdata_q <= sl_rdata;
      end else if (wres == WR_FAIL) begin
        err_q <= 1'b1;
      end
    end
  end

  assign done  = done_q;
  assign err   = err_q;
  assign rdata = rdata_q;

  // shared signal multiplexing
  always_comb begin
    bus_cmd = (st_q == ST_ADDR);
    bus_dat = (st_q == ST_WDATA);
    bus_wr  = (bus_cmd || bus_dat) && wr_q;
    bus_ad  = '0;
    if (bus_cmd)      bus_ad = DATA_W'(addr_q);
    else if (bus_dat) bus_ad = wdata_q;
  end
endmodule

// File: rtl/ctl_bus_master.sv
module ctl_bus_master #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 16,
  parameter int TIMEOUT   = 8,
  parameter int MAX_RETRY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              retry_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] bus_ad,
  output logic              bus_cmd,
  output logic              bus_wr,
  output logic              bus_dat,
  input  logic              sl_vld,
  input  logic [DATA_W-1:0] sl_rdata
);
  logic tmr_run, tmr_expired;
  logic rty_clear, rty_bump, rty_exhausted;

  cbm_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .retry_en(retry_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .bus_ad(bus_ad), .bus_cmd(bus_cmd), .bus_wr(bus_wr), .bus_dat(bus_dat),
    .sl_vld(sl_vld), .sl_rdata(sl_rdata),
    .tmr_run(tmr_run), .tmr_expired(tmr_expired),
    .rty_clear(rty_clear), .rty_bump(rty_bump), .rty_exhausted(rty_exhausted)
  );

  cbm_resp_timer #(.TIMEOUT(TIMEOUT)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .expired(tmr_expired)
  );

  cbm_retry_ctl #(.MAX_RETRY(MAX_RETRY)) u_rty (
    .clk(clk), .rst_n(rst_n), .clear(rty_clear), .bump(rty_bump),
    .exhausted(rty_exhausted)
  );
endmodule

// File: rtl/cbm_master_chk.sv
module cbm_master_chk #(
  parameter int DATA_W  = 32,
  parameter int TIMEOUT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [DATA_W-1:0] bus_ad,
  input logic              bus_cmd,
  input logic              bus_wr,
  input logic              bus_dat,
  input logic              sl_vld
);
  localparam int CW = $clog2(TIMEOUT + 2) + 1;
  logic [CW-1:0] wcnt;

  // cycles since the last command or data cycle while in flight
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wcnt <= '0;
    else if (bus_cmd || bus_dat || !busy)
      wcnt <= '0;
    else if (wcnt != '1)
      wcnt <= wcnt + 1'b1;
  end

  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);

  // R2
  wdata_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd && bus_wr) |=> (bus_dat && bus_wr));

  // R2
  wdata_after_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dat |-> $past(bus_cmd && bus_wr));

  // R3
  read_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd && !bus_wr) |=> (!bus_dat && !bus_cmd));

  // R4
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_cmd && !bus_dat) |-> (bus_ad == '0 && !bus_wr));

  // R5
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_cmd && !bus_dat) |-> (wcnt < CW'(TIMEOUT)));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  ok_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> $past(sl_vld));

  // R7
  fail_after_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> ($past(wcnt) == CW'(TIMEOUT - 1) && !$past(sl_vld)));
endmodule

bind ctl_bus_master cbm_master_chk #(.DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) u_chk (.*);

// File: tb/sim_ctl_bus_master.sv
`timescale 1ns/1ps
module sim_ctl_bus_master;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 16;
  localparam int TIMEOUT   = 6;
  localparam int MAX_RETRY = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic retry_en, req_valid, req_ready, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic busy, done, err;
  logic [DATA_W-1:0] rdata, bus_ad, sl_rdata;
  logic bus_cmd, bus_wr, bus_dat, sl_vld;

  always #5 clk = ~clk;

  ctl_bus_master #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TIMEOUT(TIMEOUT),
                   .MAX_RETRY(MAX_RETRY)) u0 (
    .clk(clk), .rst_n(rst_n), .retry_en(retry_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .bus_ad(bus_ad), .bus_cmd(bus_cmd), .bus_wr(bus_wr), .bus_dat(bus_dat),
    .sl_vld(sl_vld), .sl_rdata(sl_rdata)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural slave
  int silent_n = 0, resp_d = 0, attempts = 0, pend = -1;
  bit stray = 0;
  bit exp_wr = 0;
  logic [DATA_W-1:0] exp_ad = '0, exp_wd = '0, rd_val = '0;

  always @(negedge clk) begin
    sl_vld = 1'b0;
    if (rst_n) begin
      if (stray) begin
        sl_vld = 1'b1;
        sl_rdata = rd_val;
      end
      if (pend == 0) begin
        sl_vld = 1'b1;
        sl_rdata = rd_val;
        pend = -1;
      end else if (pend > 0) begin
        pend--;
      end
      if (bus_cmd) begin
        attempts++;
        chk(bus_ad == exp_ad && bus_wr == exp_wr, exp_wr ? "R2" : "R3",
            "address cycle", {31'd0, bus_wr, bus_ad}, {31'd0, exp_wr, exp_ad});
      end else if (bus_dat) begin
        chk(bus_ad == exp_wd && bus_wr, "R2", "data cycle", bus_ad, exp_wd);
      end else begin
        chk(bus_ad == '0 && !bus_wr, "R4", "quiet bus", bus_ad, 0);
      end
      if ((bus_cmd && !bus_wr) || bus_dat) begin
        if (attempts > silent_n) pend = resp_d;
        if (!exp_wr && bus_dat)
          chk(1'b0, "R3", "data cycle on read", 1, 0);
      end
    end
  end

  logic [DATA_W-1:0] exp_rdata = '0;

  function automatic bool_ok(input int silent, input int d, input bit rty);
    return (d <= TIMEOUT - 1) && (silent == 0 || (rty && silent <= MAX_RETRY));
  endfunction

  function automatic int exp_cycles(input bit wr, input int silent, input int d,
                                    input bit rty);
    int p = wr ? 2 : 1;
    if (bool_ok(silent, d, rty))
      return silent * (p + TIMEOUT) + p + d + 1 + 1;
    return (rty ? MAX_RETRY + 1 : 1) * (p + TIMEOUT) + 1;
  endfunction

  task automatic run_txn(input bit wr, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] wd, input int silent,
                         input int d, input bit rty, input bit hold);
    int cyc;
    bit ok;
    int exp_att;
    ok = bool_ok(silent, d, rty);
    exp_att = ok ? silent + 1 : (rty ? MAX_RETRY + 1 : 1);
    exp_wr = wr; exp_ad = DATA_W'(a); exp_wd = wd;
    silent_n = silent; resp_d = d; attempts = 0; pend = -1;
    rd_val = $urandom;
    retry_en = rty;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    chk(req_ready, "R1", "ready when idle", req_ready, 1);
    @(posedge clk);
    @(negedge clk);
    if (hold) begin
      req_addr = ~a; req_wdata = ~wd; req_write = ~wr;
    end else begin
      req_valid = 1'b0;
    end
    chk(busy, "R1", "busy after accept", busy, 1);
    cyc = 1;
    while (!done && cyc < 1000) begin
      if (hold) chk(!req_ready, "R1", "not ready while busy", req_ready, 0);
      @(negedge clk);
      cyc++;
    end
    req_valid = 1'b0;
    chk(cyc == exp_cycles(wr, silent, d, rty), "R10", "done latency",
        cyc, exp_cycles(wr, silent, d, rty));
    chk(err == !ok, ok ? "R6" : (rty ? "R8" : "R7"), "err flag", err, !ok);
    chk(attempts == exp_att, rty ? "R8" : "R7", "attempt count", attempts, exp_att);
    if (ok && !wr) exp_rdata = rd_val;
    chk(rdata == exp_rdata, (ok && !wr) ? "R6" : "R9", "rdata", rdata, exp_rdata);
    @(negedge clk);
    chk(!done && !busy, "R6", "done one cycle", {done, busy}, 0);
    chk(err == !ok, "R9", "err held", err, !ok);
    chk(attempts == exp_att, "R5", "no extra command", attempts, exp_att);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; retry_en = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; sl_rdata = '0;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    chk(req_ready && !busy, "R1", "reset idle", {req_ready, busy}, 2);
    chk(!done && !err && rdata == '0, "R9", "reset outputs", {done, err}, 0);
    chk(bus_ad == '0 && !bus_cmd && !bus_dat && !bus_wr, "R4", "reset bus", bus_ad, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_txn(1, 16'h1234, 32'hDEADBEEF, 0, 0, 0, 0);           // R2 R6
    run_txn(0, 16'h00A5, 32'h0, 0, TIMEOUT - 1, 0, 0);         // R6 boundary
    run_txn(0, 16'h00A6, 32'h0, 0, TIMEOUT, 0, 0);             // R7 late
    run_txn(1, 16'hFFFF, 32'h0F0F0F0F, 0, TIMEOUT, 0, 1);      // R7 write late
    run_txn(0, 16'h0101, 32'h0, 1, 2, 0, 0);                   // R7 discard
    run_txn(0, 16'h0202, 32'h0, MAX_RETRY, 1, 1, 1);           // R8 last retry ok
    run_txn(1, 16'h0303, 32'h12345678, MAX_RETRY + 1, 0, 1, 0); // R8 exhausted
    run_txn(0, 16'h0404, 32'h0, 0, TIMEOUT, 1, 0);             // R8 all late

    // R5: stray strobe while idle is ignored
    rd_val = 32'hBAD0BAD0;
    stray = 1;
    @(negedge clk);
    stray = 0;
    @(negedge clk);
    chk(!done && rdata == exp_rdata, "R5", "stray strobe ignored", rdata, exp_rdata);

    for (int i = 0; i < 60; i++) begin
      bit wr = 1'($urandom_range(1, 0));
      int d = ($urandom_range(9, 0) < 8) ? int'($urandom_range(TIMEOUT - 1, 0)) : TIMEOUT;
      int s = ($urandom_range(9, 0) < 3) ? int'($urandom_range(MAX_RETRY + 1, 0)) : 0;
      run_txn(wr, 16'($urandom), $urandom, s, d, 1'($urandom_range(1, 0)),
              1'($urandom_range(1, 0)));
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule